// File: doc/BRIEF.md
# Dual-Port Direction-Coded GPIO Controller

This block drives general-purpose pins on two ports. Port A has sixteen pins and port B has four. Each port has a control register and a data register. The control register holds a 2-bit direction code for every pin. The code marks the pin as an input, an output, or unused. The data register holds the value latched for the output pins.

A simple register bus writes and reads the four registers. The block turns the codes into per-pin input and output masks and drives each port's output value and output-enable vector. When the data register is read, the bus sees the synchronized external levels on input pins merged with the latched values on output pins.

External inputs pass through a two-flop synchronizer before reads use them. Each stage of port A's synchronizer leaves reset holding the pattern 0x0300, so pins 8 and 9 read as 1 until the real pin levels arrive.

Top module: `duo_gpio`

## Requirements
- R1: While `rst_n` is low, every control and data register is zero, and `pa_out`, `pa_oe`, `pb_out` and `pb_oe` are all zero.
- R2: Register addresses are: 0 = port A control, 1 = port A data, 2 = port B control, 3 = port B data. Pin i of a port takes its direction code from control bits [2i+1:2i]. Port A uses bits [31:0] of its control register and port B uses bits [7:0] of its own.
- R3: Code 2 makes a pin an input. Codes 1 and 3 make it an output. Code 0 leaves it unused. A pin's output-enable is high exactly when its code is 1 or 3, and it changes only on a write to that port's control register.
- R4: A port's output value equals its stored data ANDed with its output-enable vector. No pin drives a 1 unless it is enabled.
- R5: A data-register read returns (synchronized input AND input mask) OR (stored data AND output mask). An unused pin reads 0.
- R6: A control write keeps the stored data. Pins that become outputs immediately drive their stored data bits.
- R7: Both synchronizer stages of port A leave reset holding 0x0300. A port A data read that uses the first synchronized sample after reset shows 1 on input pins 8 and 9. Port B's synchronizer resets to 0.
- R8: A data write stores the pin bits, but only bits of output pins reach the output lines.
- R9: A read raises `bus_rvalid` with `bus_rdata` exactly one cycle after `bus_rd`. Control reads return the stored codes. Bits above a register's width read 0, and write bits above that width are dropped.
- R10: A change on a pin input first shows in a data read issued two cycles after the change. Reads issued in the same cycle or one cycle later still show the old level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 2 | Register select |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after bus_rd |
| pa_in | input | 16 | Port A external pin levels |
| pa_out | output | 16 | Port A output value |
| pa_oe | output | 16 | Port A output enables |
| pb_in | input | 4 | Port B external pin levels |
| pb_out | output | 4 | Port B output value |
| pb_oe | output | 4 | Port B output enables |

## Verification
The reset input pattern is the hardest state to observe. It lasts only until the synchronizer takes in the first real pin sample, two edges after reset is released. The bench releases reset in the same cycle as it writes port A's control register, making pins 8 and 9 inputs. It then issues a data read on the very next cycle, so the read is captured while the reset pattern still sits in the second stage. The synchronizer latency is measured the same way: the bench changes a pin and issues reads back to back on the following cycles, which places the first new value exactly.

// File: rtl/duo_gpio_pkg.sv
package duo_gpio_pkg;
  typedef enum logic [1:0] {
    DIR_OFF     = 2'd0,
    DIR_OUT     = 2'd1,
    DIR_IN      = 2'd2,
    DIR_OUT_ALT = 2'd3
  } dir_code_e;

  localparam logic [1:0] ADDR_CTRL_A = 2'd0;
  localparam logic [1:0] ADDR_DATA_A = 2'd1;
  localparam logic [1:0] ADDR_CTRL_B = 2'd2;
  localparam logic [1:0] ADDR_DATA_B = 2'd3;

  function automatic logic code_is_in(input logic [1:0] c);
    return c == DIR_IN;
  endfunction

  function automatic logic code_is_out(input logic [1:0] c);
    return (c == DIR_OUT) || (c == DIR_OUT_ALT);
  endfunction
endpackage

// File: rtl/duo_gpio_dir_decode.sv
module duo_gpio_dir_decode #(
  parameter int NPINS = 16
) (
  input  logic [2*NPINS-1:0] ctrl,
  output logic [NPINS-1:0]   in_mask,
  output logic [NPINS-1:0]   out_mask
);
  import duo_gpio_pkg::*;

  for (genvar g = 0; g < NPINS; g++) begin : g_pin
    assign in_mask[g]  = code_is_in(ctrl[2*g +: 2]);
    assign out_mask[g] = code_is_out(ctrl[2*g +: 2]);
  end
endmodule

// File: rtl/duo_gpio_sync.sv
module duo_gpio_sync #(
  parameter int               W   = 16,
  parameter logic [W-1:0]     RST = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= RST;
      q      <= RST;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/duo_gpio_port.sv
module duo_gpio_port #(
  parameter int               NPINS  = 16,
  parameter logic [NPINS-1:0] IN_RST = '0,
  localparam int              CW     = 2 * NPINS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctrl_we,
  input  logic             data_we,
  input  logic [CW-1:0]    ctrl_wd,
  input  logic [NPINS-1:0] data_wd,
  input  logic [NPINS-1:0] pin_in,
  output logic [NPINS-1:0] pin_out,
  output logic [NPINS-1:0] pin_oe,
  output logic [CW-1:0]    ctrl_q,
  output logic [NPINS-1:0] rd_merge
);
  logic [NPINS-1:0] data_q;
  logic [NPINS-1:0] in_mask;
  logic [NPINS-1:0] out_mask;
  logic [NPINS-1:0] in_sync;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      data_q <= '0;
    end else begin
      if (ctrl_we) ctrl_q <= ctrl_wd;
      if (data_we) data_q <= data_wd;
    end
  end

  duo_gpio_dir_decode #(.NPINS(NPINS)) u_dec (
    .ctrl     (ctrl_q),
    .in_mask  (in_mask),
    .out_mask (out_mask)
  );

  duo_gpio_sync #(.W(NPINS), .RST(IN_RST)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (pin_in),
    .q     (in_sync)
  );

  assign pin_oe   = out_mask;
  assign pin_out  = data_q & out_mask;
  assign rd_merge = (in_sync & in_mask) | (data_q & out_mask);
endmodule

// File: rtl/duo_gpio.sv
module duo_gpio #(
  parameter int                  PA_PINS   = 16,
  parameter int                  PB_PINS   = 4,
  parameter int                  DW        = 32,
  parameter logic [PA_PINS-1:0]  PA_IN_RST = 16'h0300
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [1:0]         bus_addr,
  input  logic [DW-1:0]      bus_wdata,
  output logic [DW-1:0]      bus_rdata,
  output logic               bus_rvalid,
  input  logic [PA_PINS-1:0] pa_in,
  output logic [PA_PINS-1:0] pa_out,
  output logic [PA_PINS-1:0] pa_oe,
  input  logic [PB_PINS-1:0] pb_in,
  output logic [PB_PINS-1:0] pb_out,
  output logic [PB_PINS-1:0] pb_oe
);
  import duo_gpio_pkg::*;

  localparam int ACW = 2 * PA_PINS;
  localparam int BCW = 2 * PB_PINS;

  // named write events
  wire wr_ctrl_a = bus_wr && (bus_addr == ADDR_CTRL_A);
  wire wr_data_a = bus_wr && (bus_addr == ADDR_DATA_A);
  wire wr_ctrl_b = bus_wr && (bus_addr == ADDR_CTRL_B);
  wire wr_data_b = bus_wr && (bus_addr == ADDR_DATA_B);

  logic [ACW-1:0]     ctrl_a;
  logic [BCW-1:0]     ctrl_b;
  logic [PA_PINS-1:0] merge_a;
  logic [PB_PINS-1:0] merge_b;
  logic [DW-1:0]      rd_mux;

  duo_gpio_port #(.NPINS(PA_PINS), .IN_RST(PA_IN_RST)) u_port_a (
    .clk      (clk),
    .rst_n    (rst_n),
    .ctrl_we  (wr_ctrl_a),
    .data_we  (wr_data_a),
    .ctrl_wd  (bus_wdata[ACW-1:0]),
    .data_wd  (bus_wdata[PA_PINS-1:0]),
    .pin_in   (pa_in),
    .pin_out  (pa_out),
    .pin_oe   (pa_oe),
    .ctrl_q   (ctrl_a),
    .rd_merge (merge_a)
  );

  duo_gpio_port #(.NPINS(PB_PINS), .IN_RST('0)) u_port_b (
    .clk      (clk),
    .rst_n    (rst_n),
    .ctrl_we  (wr_ctrl_b),
    .data_we  (wr_data_b),
    .ctrl_wd  (bus_wdata[BCW-1:0]),
    .data_wd  (bus_wdata[PB_PINS-1:0]),
    .pin_in   (pb_in),
    .pin_out  (pb_out),
    .pin_oe   (pb_oe),
    .ctrl_q   (ctrl_b),
    .rd_merge (merge_b)
  );

  always_comb begin
    case (bus_addr)
      ADDR_CTRL_A: rd_mux = DW'(ctrl_a);
      ADDR_DATA_A: rd_mux = DW'(merge_a);
      ADDR_CTRL_B: rd_mux = DW'(ctrl_b);
      default:     rd_mux = DW'(merge_b);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rvalid <= 1'b0;
      bus_rdata  <= '0;
    end else begin
      bus_rvalid <= bus_rd;
      if (bus_rd) bus_rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/duo_gpio_chk.sv
module duo_gpio_chk #(
  parameter int PA = 16,
  parameter int PB = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_wr,
  input logic          bus_rd,
  input logic [1:0]    bus_addr,
  input logic          bus_rvalid,
  input logic [PA-1:0] pa_out,
  input logic [PA-1:0] pa_oe,
  input logic [PB-1:0] pb_out,
  input logic [PB-1:0] pb_oe
);
  // R1: outputs quiet under reset
  a_r1_reset_quiet: assert property (@(posedge clk)
    !rst_n |-> (pa_oe == '0 && pa_out == '0 && pb_oe == '0 && pb_out == '0));

  // R4: nothing driven beyond the enables
  a_r4_out_within_oe_a: assert property (@(posedge clk) disable iff (!rst_n)
    (pa_out & ~pa_oe) == '0);
  a_r4_out_within_oe_b: assert property (@(posedge clk) disable iff (!rst_n)
    (pb_out & ~pb_oe) == '0);

  // R3: enables change only after a control write
  a_r3_oe_a_held: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && bus_addr == 2'd0) |=> $stable(pa_oe));
  a_r3_oe_b_held: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && bus_addr == 2'd2) |=> $stable(pb_oe));

  // R9: read response exactly one cycle later
  a_r9_rvalid_after_rd: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd |=> bus_rvalid);
  a_r9_no_spurious_rvalid: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> !bus_rvalid);
endmodule

bind duo_gpio duo_gpio_chk #(.PA(PA_PINS), .PB(PB_PINS)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_wr     (bus_wr),
  .bus_rd     (bus_rd),
  .bus_addr   (bus_addr),
  .bus_rvalid (bus_rvalid),
  .pa_out     (pa_out),
  .pa_oe      (pa_oe),
  .pb_out     (pb_out),
  .pb_oe      (pb_oe)
);

// File: tb/duo_gpio_bench.sv
module duo_gpio_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic [31:0] bus_wdata = 32'd0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid;
  logic [15:0] pa_in = 16'd0;
  logic [15:0] pa_out, pa_oe;
  logic [3:0]  pb_in = 4'd0;
  logic [3:0]  pb_out, pb_oe;

  int tests = 0;
  int fails = 0;

  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #10 clk = ~clk;

  duo_gpio u_duo_gpio (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
    .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // driver: called at a falling edge, returns at the next falling edge
  task automatic bus_write(input logic [1:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, input logic [31:0] exp, input string tag);
    exp_q.push_back(exp); tag_q.push_back(tag);
    bus_rd = 1'b1; bus_addr = a;
    @(posedge clk); @(negedge clk);
    bus_rd = 1'b0;
  endtask

  // monitor: pops expected read data as responses appear
  always @(negedge clk) begin
    if (rst_n && bus_rvalid) begin
      if (exp_q.size() == 0) begin
        check("R9 unexpected rvalid", 32'd1, 32'd0);
      end else begin
        check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
      end
    end
  end

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    check("watchdog expired", 32'd1, 32'd0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 pa_oe in reset", {16'd0, pa_oe}, 32'd0);
    check("R1 pa_out in reset", {16'd0, pa_out}, 32'd0);
    check("R1 pb outputs in reset", {24'd0, pb_oe, pb_out}, 32'd0);

    // R7: release reset together with a control write, read on the next cycle
    rst_n = 1'b1;
    bus_write(2'd0, 32'h000A_0000);            // pins 8,9 code 2
    bus_read(2'd1, 32'h0000_0300, "R7 reset input pattern");
    bus_read(2'd0, 32'h000A_0000, "R2 R9 ctrl A readback");
    bus_read(2'd2, 32'h0000_0000, "R1 ctrl B after reset");

    // R8: data on non-output pins stays off the lines
    bus_write(2'd1, 32'h0000_FFFF);
    check("R8 no output on input pins", {16'd0, pa_out}, 32'd0);

    // R6 R3: all pins code 1 -> stored data appears
    bus_write(2'd0, 32'h5555_5555);
    check("R3 all-output oe", {16'd0, pa_oe}, 32'h0000_FFFF);
    check("R6 data reapplied", {16'd0, pa_out}, 32'h0000_FFFF);

    // mixed codes: pins0-3=3, 4-7=2, 8-11=0, 12-15=1
    pa_in = 16'h0F5A;
    bus_write(2'd0, 32'h5500_AAFF);
    check("R2 R3 mixed oe", {16'd0, pa_oe}, 32'h0000_F00F);
    check("R6 mixed out", {16'd0, pa_out}, 32'h0000_F00F);
    repeat (3) @(negedge clk);
    bus_read(2'd1, 32'h0000_F05F, "R5 merged read, unused pins 0");

    bus_write(2'd1, 32'h0000_1234);
    check("R4 out masked by oe", {16'd0, pa_out}, 32'h0000_1004);

    // R10: synchronizer latency
    pa_in = 16'h00A0;
    bus_read(2'd1, 32'h0000_1054, "R10 same-cycle read old");
    bus_read(2'd1, 32'h0000_1054, "R10 next-cycle read old");
    bus_read(2'd1, 32'h0000_10A4, "R10 two-cycle read new");

    // port B: pin0=1, pin1=2, pin2=3, pin3=0; upper write bits dropped
    pb_in = 4'hF;
    bus_write(2'd2, 32'hFFFF_FF39);
    bus_write(2'd3, 32'hFFFF_FFFF);
    check("R3 port B oe", {28'd0, pb_oe}, 32'h5);
    check("R8 port B out", {28'd0, pb_out}, 32'h5);
    bus_read(2'd2, 32'h0000_0039, "R9 ctrl B width");
    bus_read(2'd3, 32'h0000_0007, "R5 port B merged read");

    bus_write(2'd2, 32'h0000_0055);
    check("R6 port B reapply", {28'd0, pb_out}, 32'hF);

    // all unused: reads 0 despite driven inputs
    pa_in = 16'hFFFF;
    bus_write(2'd0, 32'h0000_0000);
    check("R3 oe off when unused", {16'd0, pa_oe}, 32'd0);
    repeat (3) @(negedge clk);
    bus_read(2'd1, 32'h0000_0000, "R5 unused pins read 0");

    repeat (3) @(negedge clk);
    check("R9 all reads answered", exp_q.size(), 32'd0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule